// File: doc/BRIEF.md
# Two-Channel Serial Audio Capture Master

This block is the clocking end of a two-microphone serial audio link. It divides the system clock to produce the bit clock, and derives from it a word-select line that completes one stereo frame every 64 bit-clock periods. The two microphones share a single data wire. One microphone drives the data wire while word-select is low, which is the left slot. The other drives it while word-select is high, which is the right slot. Outside its own slot each microphone releases the wire, and a pull-down holds it low.

Each 32-bit slot is tracked by a slot state machine. Its states are ST_INIT, which waits for the first falling bit-clock edge after reset, then ST_L_DELAY, ST_L_BITS and ST_L_PAD for the left slot, then ST_R_DELAY, ST_R_BITS and ST_R_PAD for the right slot. Every transition happens on a falling edge of the bit clock:

- INIT goes to L_DELAY.
- L_DELAY goes to L_BITS.
- L_BITS goes to L_PAD after the 24th data period.
- L_PAD goes to R_DELAY at the end of the 32nd period.
- The right slot repeats the same pattern.
- R_PAD returns to L_DELAY.

During the two BITS states the data line is shifted into a single 24-bit register on each rising bit-clock edge. The finished word of a slot is published with a one-cycle valid pulse at the next word-select edge. For a number of frames after reset, set by a parameter, nothing is published, so the silent wake-up interval of the microphones is skipped.

Top module: `i2s_stereo_rx`

## Requirements
- R1: `sck_o` is a 50 % duty square wave. Each of its levels lasts exactly HALF_DIV system clock cycles. The default of 8 at a 50 MHz clock gives 3.125 MHz, which lies inside the legal 0.5 to 3.2 MHz bit-clock range.
- R2: `ws_o` changes only in the cycle in which `sck_o` falls. Each frame lasts 64 rising edges of `sck_o`, with `ws_o` low for 32 of them (left slot) and high for 32 (right slot).
- R3: `sd_i` is sampled at rising `sck_o` edges. The bits sampled in periods 2 to 25 of a slot, counted from the word-select edge as period 1, form the word MSB first in two's complement. The first of those bits is bit 23 of the output.
- R4: The level of `sd_i` in period 1 of each slot and in periods 26 to 32 has no effect on any published word.
- R5: `left_valid` is a single-cycle pulse in the cycle in which `ws_o` rises. `left_data` then carries the left word of the frame whose left slot just ended.
- R6: `right_valid` is a single-cycle pulse in the cycle in which `ws_o` falls. `right_data` then carries the right word of the frame that just ended.
- R7: For the first SKIP_FRAMES frames after reset, neither valid pulses and both data outputs stay zero. Frames are counted from the first falling edge of `ws_o`.
- R8: `left_data` and `right_data` hold their values between their own valid pulses.
- R9: While reset is applied, `sck_o` is 0, `ws_o` is 1, both valid outputs are 0 and both data outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sd_i | input | 1 | Shared serial data line from both microphones |
| sck_o | output | 1 | Bit clock to the microphones |
| ws_o | output | 1 | Word select; low for left slot, high for right slot |
| left_data | output | 24 | Last published left word, signed |
| left_valid | output | 1 | One-cycle strobe for a new left word |
| right_data | output | 24 | Last published right word, signed |
| right_valid | output | 1 | One-cycle strobe for a new right word |

## Verification
A slot state machine that is off by one period shows at the ports within one frame of 1024 system cycles. The published words then appear bit-shifted, or they pick up noise that the bench drives in the delay and padding periods. A wrong exit from a PAD state stretches or shrinks the word-select half-period, and the frame-length and edge-alignment checks catch this at the next word-select edge. An error in the start-up frame counter shows up as a valid pulse that comes one frame early or one frame late.

// File: rtl/i2s_rx_pkg.sv
package i2s_rx_pkg;

    typedef enum logic [2:0] {
        ST_INIT,
        ST_L_DELAY,
        ST_L_BITS,
        ST_L_PAD,
        ST_R_DELAY,
        ST_R_BITS,
        ST_R_PAD
    } slot_state_t;

    localparam int NUM_CHANNELS = 2;

endpackage

// File: rtl/i2s_sck_gen.sv
module i2s_sck_gen #(
    parameter int HALF_DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    output logic sck,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] div_cnt;
    logic          at_last;

    assign at_last   = (div_cnt == LAST);
    assign rise_tick = at_last && !sck;
    assign fall_tick = at_last && sck;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_cnt <= '0;
            sck     <= 1'b0;
        end else if (at_last) begin
            div_cnt <= '0;
            sck     <= ~sck;
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/i2s_slot_fsm.sv
module i2s_slot_fsm
    import i2s_rx_pkg::*;
#(
    parameter int SLOT_BITS = 32,
    parameter int WORD_BITS = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rise_tick,
    input  logic fall_tick,
    output logic ws,
    output logic shift_en,
    output logic pub_left,
    output logic pub_right
);
    localparam int IW = $clog2(SLOT_BITS);
    localparam logic [IW-1:0] WORD_END = IW'(WORD_BITS);
    localparam logic [IW-1:0] SLOT_END = IW'(SLOT_BITS - 1);

    slot_state_t   state_q, state_d;
    logic [IW-1:0] bit_idx;

    // next state, taken at the next falling bit-clock edge
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_INIT:    state_d = ST_L_DELAY;
            ST_L_DELAY: state_d = ST_L_BITS;
            ST_L_BITS:  if (bit_idx == WORD_END) state_d = ST_L_PAD;
            ST_L_PAD:   if (bit_idx == SLOT_END) state_d = ST_R_DELAY;
            ST_R_DELAY: state_d = ST_R_BITS;
            ST_R_BITS:  if (bit_idx == WORD_END) state_d = ST_R_PAD;
            ST_R_PAD:   if (bit_idx == SLOT_END) state_d = ST_L_DELAY;
            default:    state_d = ST_INIT;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_INIT;
        else if (fall_tick)
            state_q <= state_d;
    end

    // registered outputs: word select and slot position
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ws      <= 1'b1;
            bit_idx <= '0;
        end else if (fall_tick) begin
            ws <= (state_d == ST_R_DELAY) || (state_d == ST_R_BITS) ||
                  (state_d == ST_R_PAD);
            if ((state_d == ST_L_DELAY) || (state_d == ST_R_DELAY))
                bit_idx <= '0;
            else
                bit_idx <= bit_idx + 1'b1;
        end
    end

    assign shift_en  = rise_tick &&
                       ((state_q == ST_L_BITS) || (state_q == ST_R_BITS));
    assign pub_left  = fall_tick && (state_q == ST_L_PAD) &&
                       (state_d == ST_R_DELAY);
    assign pub_right = fall_tick && (state_q == ST_R_PAD) &&
                       (state_d == ST_L_DELAY);
endmodule

// File: rtl/i2s_word_capture.sv
module i2s_word_capture
    import i2s_rx_pkg::*;
#(
    parameter int WORD_BITS   = 24,
    parameter int SKIP_FRAMES = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        sd,
    input  logic                        shift_en,
    input  logic                        pub_left,
    input  logic                        pub_right,
    output logic signed [WORD_BITS-1:0] left_data,
    output logic                        left_valid,
    output logic signed [WORD_BITS-1:0] right_data,
    output logic                        right_valid
);
    localparam int SKW = $clog2(SKIP_FRAMES + 2);
    localparam logic [SKW-1:0] SKIP_LIM = SKW'(SKIP_FRAMES);

    logic [WORD_BITS-1:0]    shreg;
    logic [SKW-1:0]          skip_cnt;
    logic                    live;
    logic [NUM_CHANNELS-1:0] pub;

    assign live = (skip_cnt == SKIP_LIM);
    assign pub  = {pub_right, pub_left};

    // one shifter serves both slots: they never overlap in time
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            shreg <= '0;
        else if (shift_en)
            shreg <= {shreg[WORD_BITS-2:0], sd};
    end

    // frames end with the right word; count them until the mute ends
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            skip_cnt <= '0;
        else if (pub_right && !live)
            skip_cnt <= skip_cnt + 1'b1;
    end

    for (genvar ch = 0; ch < NUM_CHANNELS; ch++) begin : g_ch
        logic [WORD_BITS-1:0] word_r;
        logic                 vld_r;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_r <= '0;
                vld_r  <= 1'b0;
            end else begin
                vld_r <= pub[ch] && live;
                if (pub[ch] && live)
                    word_r <= shreg;
            end
        end
    end

    assign left_data   = g_ch[0].word_r;
    assign left_valid  = g_ch[0].vld_r;
    assign right_data  = g_ch[1].word_r;
    assign right_valid = g_ch[1].vld_r;
endmodule

// File: rtl/i2s_stereo_rx.sv
module i2s_stereo_rx #(
    parameter int HALF_DIV    = 8,
    parameter int SLOT_BITS   = 32,
    parameter int WORD_BITS   = 24,
    parameter int SKIP_FRAMES = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        sd_i,
    output logic                        sck_o,
    output logic                        ws_o,
    output logic signed [WORD_BITS-1:0] left_data,
    output logic                        left_valid,
    output logic signed [WORD_BITS-1:0] right_data,
    output logic                        right_valid
);
    logic rise_tick, fall_tick;
    logic shift_en, pub_left, pub_right;

    i2s_sck_gen #(
        .HALF_DIV(HALF_DIV)
    ) u_sck (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck      (sck_o),
        .rise_tick(rise_tick),
        .fall_tick(fall_tick)
    );

    i2s_slot_fsm #(
        .SLOT_BITS(SLOT_BITS),
        .WORD_BITS(WORD_BITS)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise_tick(rise_tick),
        .fall_tick(fall_tick),
        .ws       (ws_o),
        .shift_en (shift_en),
        .pub_left (pub_left),
        .pub_right(pub_right)
    );

    i2s_word_capture #(
        .WORD_BITS  (WORD_BITS),
        .SKIP_FRAMES(SKIP_FRAMES)
    ) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .sd         (sd_i),
        .shift_en   (shift_en),
        .pub_left   (pub_left),
        .pub_right  (pub_right),
        .left_data  (left_data),
        .left_valid (left_valid),
        .right_data (right_data),
        .right_valid(right_valid)
    );
endmodule

// File: rtl/i2s_stereo_rx_chk.sv
module i2s_stereo_rx_chk #(
    parameter int HALF_DIV    = 8,
    parameter int WORD_BITS   = 24,
    parameter int SKIP_FRAMES = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 sck_o,
    input logic                 ws_o,
    input logic [WORD_BITS-1:0] left_data,
    input logic                 left_valid,
    input logic [WORD_BITS-1:0] right_data,
    input logic                 right_valid
);
    logic        sck_q, seen_tog, ws_q;
    int unsigned run_len;
    int unsigned rises_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q      <= 1'b0;
            seen_tog   <= 1'b0;
            run_len    <= 1;
            ws_q       <= 1'b1;
            rises_seen <= 0;
        end else begin
            sck_q <= sck_o;
            ws_q  <= ws_o;
            if (sck_o != sck_q) begin
                if (seen_tog)
                    AST_SCK_HALF_PERIOD: assert (run_len == HALF_DIV); // R1
                seen_tog <= 1'b1;
                run_len  <= 1;
            end else begin
                run_len <= run_len + 1;
            end
            if (ws_o && !ws_q && rises_seen < 1000)
                rises_seen <= rises_seen + 1;
        end
    end

    AST_WS_ON_SCK_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (ws_o != $past(ws_o)) |-> ($past(sck_o) && !sck_o)); // R2
    AST_LEFT_AT_WS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        left_valid |-> $rose(ws_o)); // R5
    AST_RIGHT_AT_WS_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        right_valid |-> $fell(ws_o)); // R6
    AST_LEFT_MUTED: assert property (@(posedge clk) disable iff (!rst_n)
        left_valid |-> (rises_seen >= SKIP_FRAMES)); // R7
    AST_RIGHT_MUTED: assert property (@(posedge clk) disable iff (!rst_n)
        right_valid |-> (rises_seen > SKIP_FRAMES)); // R7
    AST_LEFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !left_valid |-> $stable(left_data)); // R8
    AST_RIGHT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !right_valid |-> $stable(right_data)); // R8
endmodule

bind i2s_stereo_rx i2s_stereo_rx_chk #(
    .HALF_DIV   (HALF_DIV),
    .WORD_BITS  (WORD_BITS),
    .SKIP_FRAMES(SKIP_FRAMES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sck_o      (sck_o),
    .ws_o       (ws_o),
    .left_data  (left_data),
    .left_valid (left_valid),
    .right_data (right_data),
    .right_valid(right_valid)
);

// File: tb/tb_i2s_stereo_rx.sv
module tb_i2s_stereo_rx;
    localparam int HALF = 8;
    localparam int SKIP = 2;
    localparam int NFR  = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sd = 1'b0;
    logic sck_o, ws_o, left_valid, right_valid;
    logic signed [23:0] left_data, right_data;

    always #10 clk = ~clk;

    i2s_stereo_rx #(
        .HALF_DIV(HALF), .SLOT_BITS(32), .WORD_BITS(24), .SKIP_FRAMES(SKIP)
    ) dut (
        .clk(clk), .rst_n(rst_n), .sd_i(sd), .sck_o(sck_o), .ws_o(ws_o),
        .left_data(left_data), .left_valid(left_valid),
        .right_data(right_data), .right_valid(right_valid)
    );

    int total = 0;
    int bad = 0;
    logic [23:0] exp_l [NFR];
    logic [23:0] exp_r [NFR];

    task automatic chk(input bit ok, input string req,
                       input logic [23:0] act, input logic [23:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] pick_word(input int f, input bit right);
        if (f == SKIP)     return right ? 24'h7FFFFF : 24'h800000;
        if (f == SKIP + 1) return right ? 24'h000001 : 24'hFFFFFF;
        if (f == SKIP + 2) return right ? 24'hAAAAAA : 24'h000000;
        return 24'($urandom());
    endfunction

    // microphone pair model: drives on falling bit clock, noise outside data periods
    int   mic_f = -1;
    int   mic_c = 0;
    logic mic_ws = 1'b1;
    always @(negedge sck_o) begin
        logic [23:0] w;
        #1;
        if (ws_o != mic_ws) begin
            mic_ws = ws_o;
            mic_c  = 0;
            if (!ws_o) mic_f++;
        end else begin
            mic_c++;
        end
        if (mic_f >= 0 && mic_f < NFR)
            w = mic_ws ? exp_r[mic_f] : exp_l[mic_f];
        else
            w = 24'h0;
        if (mic_c >= 1 && mic_c <= 24)
            sd = w[24 - mic_c];
        else
            sd = mic_f[0] ? 1'($urandom()) : 1'b0;
    end

    // port monitor, sampled on the falling system clock
    int   mon_f = -1;
    logic sck_prev = 1'b0, ws_prev = 1'b1;
    int   sck_run = 0, sck_tog = 0, sck_bad = 0;
    int   ws_bad = 0, rises = 0, len_bad = 0, stray = 0;
    bit   len_armed = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (sck_o != sck_prev) begin
                if (sck_tog > 0 && sck_run != HALF) sck_bad++;
                sck_tog++;
                sck_run = 1;
                if (sck_o) rises++;
            end else begin
                sck_run++;
            end
            if (ws_o != ws_prev) begin
                if (!(sck_prev && !sck_o)) ws_bad++;
            end
            if (ws_o && !ws_prev) begin
                if (mon_f >= SKIP && mon_f < NFR)
                    chk(left_valid && left_data == exp_l[mon_f],
                        "R3/R4/R5 left word", left_data, exp_l[mon_f]);
                else
                    chk(!left_valid && left_data == 0, "R7 left muted",
                        left_data, 24'h0);
            end else if (!ws_o && ws_prev) begin
                if (len_armed && rises != 64) len_bad++;
                len_armed = 1;
                rises = 0;
                if (mon_f >= SKIP && mon_f < NFR) begin
                    chk(right_valid && right_data == exp_r[mon_f],
                        "R3/R4/R6 right word", right_data, exp_r[mon_f]);
                    chk(!left_valid && left_data == exp_l[mon_f],
                        "R8 left held", left_data, exp_l[mon_f]);
                end else begin
                    chk(!right_valid && right_data == 0, "R7 right muted",
                        right_data, 24'h0);
                end
                mon_f++;
            end else if (left_valid || right_valid) begin
                stray++;
            end
            sck_prev = sck_o;
            ws_prev  = ws_o;
        end
    end

    bit timed_out = 0;
    initial begin
        void'($urandom(32'h5EED_0421));
        for (int f = 0; f < NFR; f++) begin
            exp_l[f] = pick_word(f, 1'b0);
            exp_r[f] = pick_word(f, 1'b1);
        end
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk(sck_o == 1'b0, "R9 sck reset", {23'h0, sck_o}, 24'h0);
        chk(ws_o == 1'b1, "R9 ws reset", {23'h0, ws_o}, 24'h1);
        chk(!left_valid && !right_valid, "R9 valid reset",
            {22'h0, left_valid, right_valid}, 24'h0);
        chk(left_data == 0 && right_data == 0, "R9 data reset",
            left_data | right_data, 24'h0);
        rst_n = 1'b1;
        fork
            wait (mon_f >= NFR);
            begin
                repeat (150000) @(posedge clk);
                timed_out = 1;
            end
        join_any
        disable fork;
        if (timed_out) chk(1'b0, "WATCHDOG", 24'h0, 24'h1);
        chk(sck_bad == 0 && sck_tog > 100, "R1 sck half period",
            24'(sck_bad), 24'h0);
        chk(ws_bad == 0, "R2 ws on sck fall", 24'(ws_bad), 24'h0);
        chk(len_bad == 0, "R2 frame 64 sck", 24'(len_bad), 24'h0);
        chk(stray == 0, "R5/R6 no stray valid", 24'(stray), 24'h0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule